// File: doc/BRIEF.md
# Pixel Word to Pulse Item Refill Writer

This block feeds the item memory of a pulse playback engine that drives a single-wire LED strip. A frame is a count of 32-bit pixel words. The writer fetches the words from a source and turns each bit, most significant bit first, into one of two preset pulse items: one for a 1 bit and one for a 0 bit. Each item holds the high time and the low time for its bit. The item memory is split into two halves. Each fill writes one whole half, and a fill always uses whole pixel words.

On a frame start the writer fills both halves back to back and then pulses a start strobe to the engine. After that, the engine raises a refill request each time a half has drained. The writer services the request when a grant arrives, which models the latency of the service path. The writer measures the time since its last fill. If the grant comes later than 1.75 times the expected fill interval while words are still left, the writer gives up on the frame. It writes the pending half as zero items, which end playback. It also records the late interval and the word index it had reached. Memory ownership is moved to software for each fill and handed back to hardware when the fill is done.

Top module: `pixel_pulse_refill`

## Requirements
- R1: While reset is held and just after it, mem_we_o, own_sw_o, tx_start_o and abort_o are 0, and abort_interval_o and abort_word_o are 0.
- R2: Item k of a word (k = 0 for the first item written) is one_item_i when bit 31-k of the word is 1, and zero_item_i when that bit is 0. Consecutive words go to consecutive address ranges, and within a fill the address rises by 1 on each write.
- R3: A start_i accepted while idle or waiting fills addresses 0 to H-1 from the first words, then H to 2H-1 from the next words, where H is HALF_ITEMS. tx_start_o is high for one cycle, in the cycle after the last of those 2H writes.
- R4: If the words run out partway through a fill, every remaining item of that fill is written as 0.
- R5: Once all words are consumed, each serviced refill writes a whole half of 0 items. The halves alternate, so the first refill after the start writes half 0.
- R6: A refill is serviced on the edge where refill_gnt_i is 1 and either refill_req_i is 1 or an earlier request is still pending. A grant with no request writes nothing and leaves own_sw_o low.
- R7: The fill interval w is counted from 0 in the cycle after a fill's last write, and it grows by 1 each cycle up to the edge that samples the grant. The limit is L = E + floor(3E/4), with E = (t1_i+t2_i+t3_i)*H. If w <= L, the fill is normal. If w > L and words remain, abort_o rises, no further words are consumed, and the pending half plus every later half is written with 0 items.
- R8: abort_o stays at 1 until the next accepted start_i clears it. On an abort, abort_interval_o captures w and abort_word_o captures the index of the next unconsumed word. Both hold their values afterwards.
- R9: When no words remain, the lateness check is skipped: a late refill sets no abort and does not change the latched values.
- R10: own_sw_o goes high one cycle before the first write of each fill and stays high through its last write. mem_we_o is only ever 1 while own_sw_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame; accepted when idle or waiting |
| word_count_i | input | CNT_W | Number of pixel words in the frame |
| t1_i | input | T_W | First bit-timing term, in cycles |
| t2_i | input | T_W | Second bit-timing term |
| t3_i | input | T_W | Third bit-timing term |
| one_item_i | input | ITEM_W | Item written for a 1 bit |
| zero_item_i | input | ITEM_W | Item written for a 0 bit |
| word_addr_o | output | CNT_W | Index of the pixel word being read |
| word_i | input | 32 | Pixel word at word_addr_o, read in the same cycle |
| refill_req_i | input | 1 | Engine asks for the next half |
| refill_gnt_i | input | 1 | Service grant; models the service latency |
| mem_we_o | output | 1 | Item memory write enable |
| mem_addr_o | output | ADDR_W | Item memory address; top bit selects the half |
| mem_data_o | output | ITEM_W | Item written |
| own_sw_o | output | 1 | Memory owned by the writer (1) or the engine (0) |
| tx_start_o | output | 1 | One-cycle start strobe after the two first fills |
| abort_o | output | 1 | Sticky frame abort flag |
| abort_interval_o | output | ELAP_W | Late interval captured at the abort |
| abort_word_o | output | CNT_W | Word index reached at the abort |

## Verification
A grant sampled on an edge raises own_sw_o in the next cycle. The writes follow for H cycles, and the cycle after the last write is the first idle cycle, with the interval counter at 0. The bench drives each request and grant at a falling edge exactly w cycles after that idle cycle, so the design measures exactly w. This lets the bench place the limit boundary on L and L+1. The bench captures the item memory at rising edges and compares whole halves only once own_sw_o has dropped. It reads tx_start_o and the abort outputs at the first falling edge after a fill, which is where their registered updates first show.

// File: rtl/refill_enc_pkg.sv
package refill_enc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GRAB,
    ST_FILL,
    ST_WAIT
  } fill_state_e;

  localparam int unsigned PIX_W = 32;
endpackage

// File: rtl/bit_item_encoder.sv
module bit_item_encoder #(
  parameter int unsigned ITEM_W = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic              blank_i,
  input  logic [ITEM_W-1:0] one_item_i,
  input  logic [ITEM_W-1:0] zero_item_i,
  output logic [ITEM_W-1:0] item_o
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word_i << bit_idx_i;
    if (blank_i)                 item_o = '0;
    else if (shifted[WORD_W-1])  item_o = one_item_i;
    else                         item_o = zero_item_i;
  end
endmodule

// File: rtl/fill_interval_watchdog.sv
module fill_interval_watchdog #(
  parameter int unsigned T_W        = 8,
  parameter int unsigned ELAP_W     = 20,
  parameter int unsigned HALF_ITEMS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [T_W-1:0]    t1_i,
  input  logic [T_W-1:0]    t2_i,
  input  logic [T_W-1:0]    t3_i,
  input  logic              restart_i,
  output logic [ELAP_W-1:0] elapsed_o,
  output logic              late_o
);
  localparam int unsigned CALC_W = ELAP_W + 4;

  logic [ELAP_W-1:0] elapsed_q;
  logic [CALC_W-1:0] bit_period;
  logic [CALC_W-1:0] expected;
  logic [CALC_W-1:0] limit;

  always_comb begin
    bit_period = CALC_W'(t1_i) + CALC_W'(t2_i) + CALC_W'(t3_i);
    expected   = bit_period * CALC_W'(HALF_ITEMS);
    limit      = expected + ((expected * CALC_W'(3)) >> 2);
    late_o     = CALC_W'(elapsed_q) > limit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                elapsed_q <= '0;
    else if (restart_i)         elapsed_q <= '0;
    else if (elapsed_q != '1)   elapsed_q <= elapsed_q + ELAP_W'(1);
  end

  assign elapsed_o = elapsed_q;
endmodule

// File: rtl/abort_capture.sv
module abort_capture #(
  parameter int unsigned ELAP_W = 20,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fire_i,
  input  logic [ELAP_W-1:0] interval_i,
  input  logic [CNT_W-1:0]  word_idx_i,
  output logic              abort_o,
  output logic [ELAP_W-1:0] interval_o,
  output logic [CNT_W-1:0]  word_idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_o    <= 1'b0;
      interval_o <= '0;
      word_idx_o <= '0;
    end else if (clear_i) begin
      abort_o    <= 1'b0;
    end else if (fire_i) begin
      abort_o    <= 1'b1;
      interval_o <= interval_i;
      word_idx_o <= word_idx_i;
    end
  end
endmodule

// File: rtl/pixel_pulse_refill.sv
module pixel_pulse_refill
  import refill_enc_pkg::*;
#(
  parameter int unsigned HALF_ITEMS = 32,
  parameter int unsigned ITEM_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned T_W        = 8,
  parameter int unsigned ELAP_W     = 20,
  localparam int unsigned IDX_W     = $clog2(HALF_ITEMS),
  localparam int unsigned ADDR_W    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  word_count_i,
  input  logic [T_W-1:0]    t1_i,
  input  logic [T_W-1:0]    t2_i,
  input  logic [T_W-1:0]    t3_i,
  input  logic [ITEM_W-1:0] one_item_i,
  input  logic [ITEM_W-1:0] zero_item_i,
  output logic [CNT_W-1:0]  word_addr_o,
  input  logic [PIX_W-1:0]  word_i,
  input  logic              refill_req_i,
  input  logic              refill_gnt_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ITEM_W-1:0] mem_data_o,
  output logic              own_sw_o,
  output logic              tx_start_o,
  output logic              abort_o,
  output logic [ELAP_W-1:0] abort_interval_o,
  output logic [CNT_W-1:0]  abort_word_o
);
  localparam int unsigned BIT_W = $clog2(PIX_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_ITEMS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PIX_W - 1);

  fill_state_e state_q;
  logic              half_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cur_q;
  logic [CNT_W-1:0]  size_q;
  logic              blank_q;
  logic [1:0]        prefill_q;
  logic              pending_q;
  logic              tx_q;

  logic              start_ok;
  logic              want;
  logic              service;
  logic              fill_end;
  logic              words_left;
  logic              zero_slot;
  logic              late;
  logic              fire;
  logic [ELAP_W-1:0] elapsed;
  logic [BIT_W-1:0]  bit_idx;

  assign start_ok   = start_i && (state_q == ST_IDLE || state_q == ST_WAIT);
  assign want       = pending_q || refill_req_i;
  assign service    = (state_q == ST_WAIT) && want && refill_gnt_i && !start_ok;
  assign fill_end   = (state_q == ST_FILL) && (idx_q == LAST_IDX);
  assign words_left = cur_q < size_q;
  assign zero_slot  = blank_q || !words_left;
  assign fire       = service && late && words_left;
  assign bit_idx    = idx_q[BIT_W-1:0];

  // Half size is a multiple of the word width, so one word maps to one aligned group of items
  generate
    if (IDX_W > BIT_W) begin : g_multi_word
      assign mem_addr_o = {half_q, idx_q};
    end else begin : g_single_word
      assign mem_addr_o = {half_q, bit_idx};
    end
  endgenerate

  bit_item_encoder #(
    .ITEM_W (ITEM_W),
    .WORD_W (PIX_W)
  ) u_encode (
    .word_i      (word_i),
    .bit_idx_i   (bit_idx),
    .blank_i     (zero_slot),
    .one_item_i  (one_item_i),
    .zero_item_i (zero_item_i),
    .item_o      (mem_data_o)
  );

  fill_interval_watchdog #(
    .T_W        (T_W),
    .ELAP_W     (ELAP_W),
    .HALF_ITEMS (HALF_ITEMS)
  ) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .t1_i      (t1_i),
    .t2_i      (t2_i),
    .t3_i      (t3_i),
    .restart_i (fill_end),
    .elapsed_o (elapsed),
    .late_o    (late)
  );

  abort_capture #(
    .ELAP_W (ELAP_W),
    .CNT_W  (CNT_W)
  ) u_abort (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_ok),
    .fire_i     (fire),
    .interval_i (elapsed),
    .word_idx_i (cur_q),
    .abort_o    (abort_o),
    .interval_o (abort_interval_o),
    .word_idx_o (abort_word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      idx_q     <= '0;
      cur_q     <= '0;
      size_q    <= '0;
      blank_q   <= 1'b0;
      prefill_q <= 2'd0;
      pending_q <= 1'b0;
      tx_q      <= 1'b0;
    end else begin
      tx_q <= 1'b0;
      if (state_q != ST_IDLE) pending_q <= want && !service;
      if (start_ok) begin
        state_q   <= ST_GRAB;
        half_q    <= 1'b0;
        idx_q     <= '0;
        cur_q     <= '0;
        size_q    <= word_count_i;
        blank_q   <= 1'b0;
        prefill_q <= 2'd2;
        pending_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_GRAB: state_q <= ST_FILL;
          ST_FILL: begin
            if (!zero_slot && bit_idx == LAST_BIT) cur_q <= cur_q + CNT_W'(1);
            if (fill_end) begin
              idx_q   <= '0;
              half_q  <= ~half_q;
              blank_q <= 1'b0;
              if (prefill_q == 2'd2) begin
                prefill_q <= 2'd1;
                state_q   <= ST_GRAB;
              end else begin
                if (prefill_q == 2'd1) tx_q <= 1'b1;
                prefill_q <= 2'd0;
                state_q   <= ST_WAIT;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          ST_WAIT: begin
            if (service) begin
              state_q <= ST_GRAB;
              if (fire) begin
                blank_q <= 1'b1;
                cur_q   <= size_q;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign word_addr_o = cur_q;
  assign mem_we_o    = (state_q == ST_FILL);
  assign own_sw_o    = (state_q == ST_GRAB) || (state_q == ST_FILL);
  assign tx_start_o  = tx_q;
endmodule

// File: rtl/pixel_pulse_refill_chk.sv
module pixel_pulse_refill_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned ITEM_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ITEM_W-1:0] mem_data_o,
  input logic              own_sw_o,
  input logic              tx_start_o,
  input logic              abort_o
);
  AST_WE_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> own_sw_o); // R10

  AST_OWN_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_sw_o) |-> !mem_we_o); // R10

  AST_TX_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(mem_we_o) && !mem_we_o); // R3

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + 1'b1); // R2

  AST_ABORT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> own_sw_o && !mem_we_o); // R7

  AST_ABORT_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && mem_we_o) |-> mem_data_o == '0); // R7

  AST_ABORT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !start_i) |=> abort_o); // R8
endmodule

bind pixel_pulse_refill pixel_pulse_refill_chk #(
  .ADDR_W (ADDR_W),
  .ITEM_W (ITEM_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .own_sw_o   (own_sw_o),
  .tx_start_o (tx_start_o),
  .abort_o    (abort_o)
);

// File: tb/pixel_pulse_refill_tb.sv
module pixel_pulse_refill_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H       = 64;
  localparam int ITEM_W  = 32;
  localparam int CNT_W   = 16;
  localparam int T_W     = 8;
  localparam int ELAP_W  = 20;
  localparam int ADDR_W  = 7;
  localparam logic [31:0] ONE  = 32'h0006_8003;
  localparam logic [31:0] ZERO = 32'h0003_8006;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] wcount = '0;
  logic [T_W-1:0] t1 = 8'd1, t2 = 8'd1, t3 = 8'd1;
  logic [CNT_W-1:0] waddr;
  logic [31:0] wdata;
  logic req = 1'b0, gnt = 1'b0;
  logic we, own, txs, abrt;
  logic [ADDR_W-1:0] addr;
  logic [ITEM_W-1:0] data;
  logic [ELAP_W-1:0] ab_int;
  logic [CNT_W-1:0] ab_word;

  logic [31:0] pix [0:15];
  logic [31:0] mem [0:2*H-1];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wdata = (waddr < 16) ? pix[waddr[3:0]] : 32'h0;

  always @(posedge clk) if (we) mem[addr] <= data;

  pixel_pulse_refill #(
    .HALF_ITEMS (H), .ITEM_W (ITEM_W), .CNT_W (CNT_W), .T_W (T_W), .ELAP_W (ELAP_W)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start), .word_count_i (wcount),
    .t1_i (t1), .t2_i (t2), .t3_i (t3), .one_item_i (ONE), .zero_item_i (ZERO),
    .word_addr_o (waddr), .word_i (wdata), .refill_req_i (req), .refill_gnt_i (gnt),
    .mem_we_o (we), .mem_addr_o (addr), .mem_data_o (data), .own_sw_o (own),
    .tx_start_o (txs), .abort_o (abrt), .abort_interval_o (ab_int), .abort_word_o (ab_word)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2*H; i++) mem[i] = 32'hFFFF_FFFF;
  endtask

  task automatic check_half(input int base, input logic [31:0] w0, input logic [31:0] w1,
                            input bit v0, input bit v1, input string tag);
    logic [31:0] e, fa, fe;
    bit ok = 1;
    fa = 0; fe = 0;
    for (int k = 0; k < H; k++) begin
      logic [31:0] w;
      bit v;
      w = (k < 32) ? w0 : w1;
      v = (k < 32) ? v0 : v1;
      e = v ? (w[31 - (k % 32)] ? ONE : ZERO) : 32'h0;
      if (mem[base + k] !== e && ok) begin
        ok = 0; fa = mem[base + k]; fe = e;
      end
    end
    chk(ok, tag, fa, fe);
  endtask

  // at a falling edge; returns at the first falling edge after the fills
  task automatic start_frame(input int n, input logic [T_W-1:0] a, input logic [T_W-1:0] b,
                             input logic [T_W-1:0] c, output int writes);
    clear_mem();
    wcount = CNT_W'(n); t1 = a; t2 = b; t3 = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    writes = 0;
    while (own) begin
      if (we) writes++;
      @(negedge clk);
    end
  endtask

  // w: interval the design measures at the grant edge
  task automatic serve(input int w, output int writes);
    repeat (w) @(negedge clk);
    req = 1'b1; gnt = 1'b1;
    @(negedge clk);
    req = 1'b0; gnt = 1'b0;
    writes = 0;
    while (own) begin
      if (we) writes++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!we && !own && !txs && !abrt, "R1 outputs in reset", {we, own, txs, abrt}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!we && !own && !txs && !abrt, "R1 outputs after reset", {we, own, txs, abrt}, 0);
    chk(ab_int == 0 && ab_word == 0, "R1 latched values", {ab_int, ab_word}, 0);
  endtask

  task automatic t_basic();
    int wr;
    pix[0] = 32'hA5A5_0F0F; pix[1] = 32'h8000_0001; pix[2] = 32'hFFFF_0000;
    pix[3] = 32'h1234_5678; pix[4] = 32'hDEAD_BEEF;
    start_frame(5, 1, 1, 1, wr);
    chk(wr == 2*H, "R3 prefill write count", wr, 2*H);
    chk(txs == 1'b1, "R3 tx_start after prefill", txs, 1);
    check_half(0, pix[0], pix[1], 1, 1, "R2 half0 words 0,1");
    check_half(H, pix[2], pix[3], 1, 1, "R3 half1 words 2,3");
    @(negedge clk);
    chk(txs == 1'b0, "R3 tx_start one cycle", txs, 0);
    serve(4, wr);
    check_half(0, pix[4], 32'h0, 1, 0, "R4 partial fill zero tail");
    chk(wr == H, "R4 fill size", wr, H);
    serve(5, wr);
    check_half(H, 32'h0, 32'h0, 0, 0, "R5 exhausted half1 zeros");
    chk(!abrt, "R7 no abort in time", abrt, 0);
  endtask

  task automatic t_grant_only();
    int wr = 0;
    bit owned = 0;
    mem[0] = 32'h5555_5555;
    gnt = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (we) wr++;
      if (own) owned = 1;
    end
    gnt = 1'b0;
    chk(wr == 0 && !owned, "R6 grant without request", wr, 0);
    chk(mem[0] == 32'h5555_5555, "R6 memory untouched", mem[0], 32'h5555_5555);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!own, "R6 request waits for grant", own, 0);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    chk(own && !we, "R10 ownership before writes", {own, we}, 2'b10);
    wr = 0;
    while (own) begin
      if (we) wr++;
      @(negedge clk);
    end
    chk(wr == H, "R6 pending request serviced", wr, H);
    check_half(0, 32'h0, 32'h0, 0, 0, "R5 halves alternate to half0");
  endtask

  task automatic t_boundary();
    int wr;
    int lim;
    for (int i = 0; i < 8; i++) pix[i] = 32'h0101_0000 * (i + 1) + 32'h0000_F00F;
    lim = (4 * H) + ((4 * H) * 3) / 4;
    start_frame(8, 2, 1, 1, wr);
    chk(wr == 2*H, "R3 prefill count 8 words", wr, 2*H);
    serve(lim, wr);
    chk(!abrt, "R7 interval equal to limit ok", abrt, 0);
    check_half(0, pix[4], pix[5], 1, 1, "R7 on-time fill data");
    serve(lim + 1, wr);
    chk(abrt, "R7 abort one past limit", abrt, 1);
    chk(ab_int == ELAP_W'(lim + 1), "R8 abort interval", ab_int, lim + 1);
    chk(ab_word == 16'd6, "R8 abort word index", ab_word, 6);
    check_half(H, 32'h0, 32'h0, 0, 0, "R7 aborted half zeros");
    serve(600, wr);
    chk(abrt && ab_int == ELAP_W'(lim + 1), "R9 latched kept after abort", ab_int, lim + 1);
    check_half(0, 32'h0, 32'h0, 0, 0, "R7 later half zeros");
  endtask

  task automatic t_exhausted_late();
    int wr;
    pix[0] = 32'hC003_0FF0; pix[1] = 32'h7FFF_FFFE;
    start_frame(2, 1, 1, 1, wr);
    chk(!abrt, "R8 start clears abort", abrt, 1'b0);
    check_half(0, pix[0], pix[1], 1, 1, "R2 two-word frame");
    check_half(H, 32'h0, 32'h0, 0, 0, "R5 second prefill zeros");
    serve(1000, wr);
    chk(!abrt, "R9 late after exhaustion no abort", abrt, 0);
    check_half(0, 32'h0, 32'h0, 0, 0, "R5 refill after exhaustion");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pix[i] = 32'h0;
    clear_mem();
    t_reset();
    t_basic();
    t_grant_only();
    t_boundary();
    t_exhausted_late();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule